// File: doc/BRIEF.md
# Quadrature Position Counter with Index Clear

This block tracks the position of a rotary or linear encoder. Two square-wave phase inputs, A and B, sit a quarter period apart. Each edge on either phase moves a 16-bit counter by one step (four-times decoding). The order in which the edges arrive sets the direction. The counter runs free: it rolls over at both ends and never reloads. A third input, the index pulse, marks a reference point once per revolution. When index clearing is enabled, the active edge of that pulse is held as a pending clear. The clear is applied at the next count-source tick, not at the moment the edge arrives.

All three encoder lines are asynchronous and pass through synchronisers. The counter only moves on cycles where the count-source tick is high. On each tick the decoder compares the synchronised phase pair with the pair it accepted on the previous tick. Rollover and index clears each raise an interrupt request. When a rollover and a clear fall on the same tick, both requests are issued, one after the other.

The control structure has three parts. A phase state machine has states PH_00, PH_10, PH_11 and PH_01, with forward, backward, hold and illegal transitions. An index latch has two states, idle and pending, with transitions called set, merge and apply. A request sequencer has states IRQ_IDLE, IRQ_FIRE and IRQ_REST, with transitions called issue, rest, reissue and drain.

Top module: `quad_index_counter`

## Requirements
- R1: While reset is asserted and right after it, `count_o` is 0x0000, `irq_o` is 0, and no index clear is pending.
- R2: The phases are encoded as {A,B} and pass through a two-stage synchroniser. On a tick, the counter rises by one when the synchronised pair moves forward in the cycle 00, 10, 11, 01, 00. It falls by one when the pair moves the opposite way. In both cases the comparison is against the pair accepted at the previous tick.
- R3: If both phases differ from the previously accepted pair at a tick, the counter does not change. That new pair still becomes the reference for the next tick.
- R4: On cycles without a tick, the counter holds its value whatever the phase inputs do.
- R5: Stepping up from 0xFFFF gives 0x0000, and stepping down from 0x0000 gives 0xFFFF. Each rollover raises one interrupt request.
- R6: While `idx_en_i` is 0, index edges set no pending clear and the counter is not cleared.
- R7: The active index edge is rising when `idx_rise_i` is 1 and falling when it is 0. An edge of the other polarity is ignored.
- R8: A detected index edge does not touch the counter until the next tick. At that tick the counter becomes 0x0000, taking priority over any phase step, and the pending clear is dropped. Several index edges before that tick merge into one clear and one request.
- R9: Each request appears on `irq_o` as a one-cycle high pulse, with at least one low cycle between pulses. A rollover and an index clear on the same tick yield two pulses. Up to three outstanding requests are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a_i | input | 1 | Encoder phase A (asynchronous) |
| phase_b_i | input | 1 | Encoder phase B (asynchronous) |
| index_i | input | 1 | Encoder index pulse (asynchronous) |
| tick_i | input | 1 | Count-source tick, one clock wide |
| idx_en_i | input | 1 | 1 enables index clearing |
| idx_rise_i | input | 1 | 1 selects the rising index edge, 0 the falling edge |
| count_o | output | 16 | Current position count |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The hardest case to reach is a rollover and an index clear landing on the same tick, which should give the double request. The stimulus first steps the count down to 0xFFFF. It then sends an index pulse and holds the tick back until the synchronised edge has been latched. Finally it moves the phases one step forward and releases a single tick, so the step that would overflow and the pending clear meet on that one edge. A behavioural model compares the count and the request line on every cycle, and a pulse counter confirms that exactly two requests follow.

// File: rtl/qic_pkg.sv
package qic_pkg;

    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_10 = 2'b10,
        PH_11 = 2'b11,
        PH_01 = 2'b01
    } phase_t;

    typedef enum logic [1:0] {
        STEP_NONE,
        STEP_UP,
        STEP_DOWN,
        STEP_BAD
    } step_t;

    typedef enum logic [1:0] {
        IRQ_IDLE,
        IRQ_FIRE,
        IRQ_REST
    } irq_state_t;

    // Next phase in the forward rotation 00 -> 10 -> 11 -> 01 -> 00
    function automatic phase_t phase_fwd(input phase_t p);
        unique case (p)
            PH_00:   phase_fwd = PH_10;
            PH_10:   phase_fwd = PH_11;
            PH_11:   phase_fwd = PH_01;
            PH_01:   phase_fwd = PH_00;
            default: phase_fwd = PH_00;
        endcase
    endfunction

endpackage

// File: rtl/qic_sync.sv
module qic_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/qic_quad_decode.sv
module qic_quad_decode
    import qic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [1:0] ab_i,
    output step_t      step_o
);
    phase_t state_q, state_d, seen;

    assign seen = phase_t'(ab_i);

    // State register: the phase accepted at the last tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_00;
        else        state_q <= state_d;
    end

    // Transitions: forward, backward, hold, illegal (all taken on a tick)
    always_comb begin
        state_d = state_q;
        if (tick_i) begin
            unique case (state_q)
                PH_00, PH_10, PH_11, PH_01: state_d = seen;
                default:                    state_d = PH_00;
            endcase
        end
    end

    // Output: direction of the move against the accepted phase
    always_comb begin
        if (seen == state_q)                 step_o = STEP_NONE;
        else if (seen == phase_fwd(state_q)) step_o = STEP_UP;
        else if (state_q == phase_fwd(seen)) step_o = STEP_DOWN;
        else                                 step_o = STEP_BAD;
    end
endmodule

// File: rtl/qic_index_latch.sv
module qic_index_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic z_i,
    input  logic en_i,
    input  logic rise_i,
    input  logic tick_i,
    output logic pend_o
);
    typedef enum logic {IDX_IDLE, IDX_PEND} idx_state_t;

    idx_state_t state_q, state_d;
    logic       z_q;
    logic       hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) z_q <= 1'b0;
        else        z_q <= z_i;
    end

    assign hit = en_i && (rise_i ? (z_i && !z_q) : (!z_i && z_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IDX_IDLE;
        else        state_q <= state_d;
    end

    // set: IDLE->PEND on an edge; merge: PEND stays on an edge;
    // apply: PEND->IDLE on a tick with no fresh edge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDX_IDLE: if (hit) state_d = IDX_PEND;
            IDX_PEND: if (!hit && tick_i) state_d = IDX_IDLE;
            default:  state_d = IDX_IDLE;
        endcase
    end

    always_comb pend_o = (state_q == IDX_PEND);

    a_r6_disabled_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !pend_o) |=> !pend_o);
endmodule

// File: rtl/qic_irq_seq.sv
module qic_irq_seq
    import qic_pkg::*;
#(
    parameter int OWED_MAX = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ev_i,
    output logic       irq_o
);
    localparam int OWED_W = $clog2(OWED_MAX + 1);

    irq_state_t        state_q, state_d;
    logic [OWED_W-1:0] owed_q;
    logic [OWED_W+1:0] sum;
    logic              take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
            owed_q  <= '0;
        end else begin
            state_q <= state_d;
            owed_q  <= (sum > (OWED_W+2)'(OWED_MAX)) ? OWED_W'(OWED_MAX)
                                                     : sum[OWED_W-1:0];
        end
    end

    // issue: IDLE->FIRE, rest: FIRE->REST, reissue: REST->FIRE, drain: REST->IDLE
    always_comb begin
        take    = 1'b0;
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (owed_q != '0) begin take = 1'b1; state_d = IRQ_FIRE; end
            IRQ_FIRE: state_d = IRQ_REST;
            IRQ_REST: begin
                if (owed_q != '0) begin take = 1'b1; state_d = IRQ_FIRE; end
                else state_d = IRQ_IDLE;
            end
            default:  state_d = IRQ_IDLE;
        endcase
        sum = (OWED_W+2)'(owed_q) + (OWED_W+2)'(ev_i) - (OWED_W+2)'(take);
    end

    always_comb irq_o = (state_q == IRQ_FIRE);

    a_r9_pulse_gap: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
endmodule

// File: rtl/quad_index_counter.sv
module quad_index_counter
    import qic_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int OWED_MAX    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_a_i,
    input  logic             phase_b_i,
    input  logic             index_i,
    input  logic             tick_i,
    input  logic             idx_en_i,
    input  logic             idx_rise_i,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [2:0]       raw, synced;
    step_t            step;
    logic             pend;
    logic             wrap;
    logic [1:0]       ev;
    logic [CNT_W-1:0] count_q;

    assign raw = {phase_a_i, phase_b_i, index_i};

    qic_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk, .rst_n, .async_i(raw), .sync_o(synced)
    );

    qic_quad_decode u_dec (
        .clk, .rst_n, .tick_i, .ab_i(synced[2:1]), .step_o(step)
    );

    qic_index_latch u_idx (
        .clk, .rst_n, .z_i(synced[0]), .en_i(idx_en_i), .rise_i(idx_rise_i),
        .tick_i, .pend_o(pend)
    );

    always_comb begin
        wrap = tick_i && ((step == STEP_UP   && count_q == CNT_TOP) ||
                          (step == STEP_DOWN && count_q == '0));
        ev   = tick_i ? (2'(pend) + 2'(wrap)) : 2'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick_i) begin
            if (pend)                   count_q <= '0;
            else if (step == STEP_UP)   count_q <= count_q + 1'b1;
            else if (step == STEP_DOWN) count_q <= count_q - 1'b1;
        end
    end

    qic_irq_seq #(.OWED_MAX(OWED_MAX)) u_irq (
        .clk, .rst_n, .ev_i(ev), .irq_o
    );

    assign count_o = count_q;

    a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(count_o));
    a_r8_index_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && pend) |=> (count_o == '0));
    a_r5_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !pend && step == STEP_UP && count_o == CNT_TOP) |=> (count_o == '0));
    a_r3_bad_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !pend && step == STEP_BAD) |=> $stable(count_o));
endmodule

// File: tb/quad_index_counter_tb.sv
module quad_index_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a = 1'b0, b = 1'b0, z = 1'b0, tick = 1'b0, en = 1'b0, rise = 1'b1;
    logic [15:0] count;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic irq_last = 1'b0;
    int gi = 0;

    always #2 clk = ~clk;

    quad_index_counter u_dut (
        .clk(clk), .rst_n(rst_n), .phase_a_i(a), .phase_b_i(b), .index_i(z),
        .tick_i(tick), .idx_en_i(en), .idx_rise_i(rise), .count_o(count), .irq_o(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [2:0] hist[$];
    int m_cnt, m_prev, m_owed, m_state;
    bit m_pend, m_zprev, m_irq;

    function automatic int ph_index(input logic [1:0] ab);
        case (ab)
            2'b00: return 0;
            2'b10: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{3'b000, 3'b000};
            m_cnt = 0; m_prev = 0; m_owed = 0; m_state = 0;
            m_pend = 0; m_zprev = 0; m_irq = 0;
        end else begin
            logic [2:0] cur;
            bit zedge, take;
            int ev, d, nxt;
            cur = hist[1];
            zedge = en && (rise ? (cur[0] && !m_zprev) : (!cur[0] && m_zprev));
            ev = 0;
            take = (m_state != 1) && (m_owed > 0);
            if (tick) begin
                d = (ph_index(cur[2:1]) - m_prev + 4) % 4;
                nxt = m_cnt;
                if (d == 1) nxt = m_cnt + 1;
                if (d == 3) nxt = m_cnt - 1;
                if (nxt > 65535 || nxt < 0) ev++;
                if (m_pend) begin ev++; m_cnt = 0; end
                else m_cnt = nxt & 16'hFFFF;
                m_prev = ph_index(cur[2:1]);
            end
            if (zedge) m_pend = 1;
            else if (tick) m_pend = 0;
            m_zprev = cur[0];
            if (m_state == 1) m_state = 2;
            else if (take) m_state = 1;
            else m_state = 0;
            m_owed = m_owed + ev - (take ? 1 : 0);
            if (m_owed > 3) m_owed = 3;
            m_irq = (m_state == 1);
            hist.push_front({a, b, z});
            void'(hist.pop_back());
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(count == m_cnt[15:0], "R2 count vs model", count, m_cnt);
            check(irq == m_irq, "R9 irq vs model", irq, m_irq);
            if (irq && !irq_last) pulses++;
        end
        irq_last = irq;
    end

    // ---------------- stimulus helpers ----------------
    task automatic set_phase(input int idx);
        gi = idx & 3;
        case (gi)
            0: begin a = 0; b = 0; end
            1: begin a = 1; b = 0; end
            2: begin a = 1; b = 1; end
            default: begin a = 0; b = 1; end
        endcase
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (7) @(negedge clk);
    endtask

    task automatic move(input int d);
        @(negedge clk) set_phase(gi + d);
        repeat (3) @(negedge clk);
        pulse_tick();
    endtask

    task automatic zlevel(input logic v);
        @(negedge clk) z = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        check(count == 16'h0, "R1 count in reset", count, 0);
        check(irq == 1'b0, "R1 irq in reset", irq, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check(count == 16'h0, "R1 count after reset", count, 0);

        for (int i = 0; i < 5; i++) move(1);
        check(count == 16'd5, "R2 forward five", count, 5);
        for (int i = 0; i < 2; i++) move(-1);
        check(count == 16'd3, "R2 backward two", count, 3);

        move(2);
        check(count == 16'd3, "R3 illegal jump holds", count, 3);

        @(negedge clk) set_phase(gi + 1);
        repeat (10) @(negedge clk);
        check(count == 16'd3, "R4 no tick holds", count, 3);
        pulse_tick();
        check(count == 16'd4, "R4 tick then steps", count, 4);

        for (int i = 0; i < 4; i++) move(-1);
        p0 = pulses;
        move(-1);
        check(count == 16'hFFFF, "R5 underflow wraps", count, 16'hFFFF);
        check(pulses == p0 + 1, "R5 underflow request", pulses - p0, 1);
        move(1);
        check(count == 16'h0, "R5 overflow wraps", count, 0);
        check(pulses == p0 + 2, "R5 overflow request", pulses - p0, 2);

        move(1); move(1);
        en = 1'b0; rise = 1'b1;
        zlevel(1); zlevel(0);
        pulse_tick();
        check(count == 16'd2, "R6 disabled index ignored", count, 2);

        en = 1'b1; rise = 1'b0;
        zlevel(1);
        pulse_tick();
        check(count == 16'd2, "R7 wrong polarity ignored", count, 2);
        p0 = pulses;
        zlevel(0);
        check(count == 16'd2, "R8 clear deferred until tick", count, 2);
        pulse_tick();
        check(count == 16'd0, "R7 falling edge clears", count, 0);
        check(pulses == p0 + 1, "R9 clear request", pulses - p0, 1);

        move(1); move(1); move(1);
        rise = 1'b1;
        zlevel(1); zlevel(0); zlevel(1); zlevel(0);
        p0 = pulses;
        move(1);
        check(count == 16'd0, "R8 clear beats step, merged", count, 0);
        check(pulses == p0 + 1, "R8 merged single request", pulses - p0, 1);

        move(-1);
        check(count == 16'hFFFF, "R5 down to top", count, 16'hFFFF);
        zlevel(1); zlevel(0);
        p0 = pulses;
        move(1);
        check(count == 16'd0, "R9 clear with overflow", count, 0);
        check(pulses == p0 + 2, "R9 two requests", pulses - p0, 2);

        repeat (10) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule